// File: doc/BRIEF.md
# Dual scanline interrupt generator

This block watches the raster line number and field flag produced by a display timing generator and raises two independent interrupt pulses when the raster enters lines chosen by software. Both target lines sit in a single 32-bit configuration word. Writing that word re-arms both comparators. A separate geometry strobe, asserted when the frame size changes, re-arms them against the new line total.

Targets are given in frame lines. In progressive mode a target matches the raster line of the same number. In interlaced mode it matches line `2*target` in an even field and line `2*target+1` in an odd field. An event fires only at the start of its line. A write made while the raster already sits on the target line therefore takes effect one field later. A target at or beyond the line total is disarmed and never fires.

Top module: `scan_irq_gen`

## Requirements
- R1: Bits 25:16 of the configuration word set target 1 and bits 9:0 set target 2. All other bits have no effect on either output.
- R2: In progressive mode (`interlace_i`=0), a channel pulses when `line_i` changes to a value equal to its target.
- R3: In interlaced mode (`interlace_i`=1), a channel matches line `2*target+field_odd_i`. That is `2*target` when `field_odd_i`=0 and `2*target+1` when `field_odd_i`=1.
- R4: A channel whose target is at or above `total_lines_i` when it is armed never pulses. This holds for a target exactly equal to the total. A target of total-1 still fires.
- R5: A pulse fires only when the raster enters a line. A configuration write made while `line_i` already equals the target produces no pulse on that line. The pulse comes at the next entry of the line.
- R6: Each pulse is high for exactly one clock. It is high in the cycle after the first clock edge at which `line_i` shows the new line.
- R7: Once armed, a channel keeps firing every field at its target line without being rewritten.
- R8: After reset both outputs are low and both targets are zero. No pulse occurs, and the geometry strobe has no effect, until the first configuration write.
- R9: After the first configuration write, `geom_wr_i` re-arms both channels against the `total_lines_i` present with the strobe. This revives a target that was disarmed by a smaller total.
- R10: The two channels act independently. Equal targets make both outputs pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | LINE_W | Current raster line from the timing generator |
| field_odd_i | input | 1 | Field parity, 1 = odd field |
| interlace_i | input | 1 | 1 selects interlaced target mapping |
| total_lines_i | input | LINE_W+1 | Number of raster lines per field |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 32 | Configuration word holding both targets |
| geom_wr_i | input | 1 | Frame geometry changed, re-arm strobe |
| irq1_o | output | 1 | Target 1 interrupt pulse |
| irq2_o | output | 1 | Target 2 interrupt pulse |

## Verification
The checks assume that `line_i` advances by at most one line per clock. They also assume that `field_odd_i` changes only together with a wrap of `line_i` to zero, and that no configuration write coincides with a line change. The stimulus steps the raster one line per cycle and toggles the field only on the wrap to zero in interlaced runs. It issues every write and geometry strobe in a cycle where the line is held, so each pulse can be attributed to one line entry and one armed target.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  localparam int CFG_W  = 32;
  localparam int NUM_CH = 2;

  // bit position of each channel's target field in the config word
  function automatic int ch_lsb(input int ch);
    return (ch == 0) ? 16 : 0;
  endfunction
endpackage

// File: rtl/sirq_line_edge.sv
module sirq_line_edge #(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  output logic              start_o
);
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_i;
  end

  assign start_o = (line_i != line_q);
endmodule

// File: rtl/sirq_cfg.sv
module sirq_cfg
  import scan_irq_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [CFG_W-1:0]               data_i,
  output logic [NUM_CH-1:0][LINE_W-1:0]  tgt_o,
  output logic [NUM_CH-1:0][LINE_W-1:0]  tgt_nxt_o,
  output logic                           seen_o
);
  logic [NUM_CH-1:0][LINE_W-1:0] tgt_q;
  logic                          seen_q;
  logic [CFG_W-1:0]              used_mask;
  logic                          unused_bits;

  always_comb begin
    used_mask = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < LINE_W; b++) used_mask[ch_lsb(c)+b] = 1'b1;
    end
  end
  assign unused_bits = ^(data_i & ~used_mask);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_field
    assign tgt_nxt_o[g] = wr_i ? data_i[ch_lsb(g) +: LINE_W] : tgt_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      tgt_q <= tgt_nxt_o;
      if (wr_i) seen_q <= 1'b1;
    end
  end

  assign tgt_o  = tgt_q;
  assign seen_o = seen_q;
endmodule

// File: rtl/sirq_chan.sv
module sirq_chan #(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] tgt_i,
  input  logic [LINE_W-1:0] tgt_nxt_i,
  input  logic              arm_i,
  input  logic [LINE_W:0]   total_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic              interlace_i,
  input  logic              start_i,
  output logic              irq_o
);
  logic            armed_q;
  logic            irq_q;
  logic [LINE_W:0] hit_line;
  logic            in_range;
  logic            fire;

  // interlaced: target counts frame lines, raster counts field-interleaved lines
  assign hit_line = interlace_i ? {tgt_i, field_odd_i} : {1'b0, tgt_i};
  assign in_range = ({1'b0, tgt_i} < total_i);
  assign fire     = armed_q & start_i & in_range & (hit_line == {1'b0, line_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (arm_i) armed_q <= ({1'b0, tgt_nxt_i} < total_i);
      irq_q <= fire;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen
  import scan_irq_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic              interlace_i,
  input  logic [LINE_W:0]   total_lines_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              geom_wr_i,
  output logic              irq1_o,
  output logic              irq2_o
);
  logic [NUM_CH-1:0][LINE_W-1:0] tgt_q;
  logic [NUM_CH-1:0][LINE_W-1:0] tgt_nxt;
  logic                          cfg_seen;
  logic                          line_start;
  logic                          arm;
  logic [NUM_CH-1:0]             irq;

  sirq_line_edge #(.LINE_W(LINE_W)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .start_o (line_start)
  );

  sirq_cfg #(.LINE_W(LINE_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .data_i    (cfg_data_i),
    .tgt_o     (tgt_q),
    .tgt_nxt_o (tgt_nxt),
    .seen_o    (cfg_seen)
  );

  // geometry strobe only re-arms once software has configured the block
  assign arm = cfg_wr_i | (geom_wr_i & cfg_seen);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sirq_chan #(.LINE_W(LINE_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tgt_i       (tgt_q[g]),
      .tgt_nxt_i   (tgt_nxt[g]),
      .arm_i       (arm),
      .total_i     (total_lines_i),
      .line_i      (line_i),
      .field_odd_i (field_odd_i),
      .interlace_i (interlace_i),
      .start_i     (line_start),
      .irq_o       (irq[g])
    );
  end

  assign irq1_o = irq[0];
  assign irq2_o = irq[1];
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
  parameter int LINE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] line_i,
  input logic              field_odd_i,
  input logic              interlace_i,
  input logic [LINE_W:0]   total_lines_i,
  input logic [LINE_W-1:0] tgt1_i,
  input logic [LINE_W-1:0] tgt2_i,
  input logic              cfg_seen_i,
  input logic              irq1_o,
  input logic              irq2_o
);
  logic [LINE_W:0] exp1, exp2;
  assign exp1 = interlace_i ? {tgt1_i, field_odd_i} : {1'b0, tgt1_i};
  assign exp2 = interlace_i ? {tgt2_i, field_odd_i} : {1'b0, tgt2_i};

  AST_IRQ1_ON_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |-> $past(exp1 == {1'b0, line_i})); // R3
  AST_IRQ2_ON_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq2_o |-> $past(exp2 == {1'b0, line_i})); // R2
  AST_IRQ1_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |-> $past({1'b0, tgt1_i} < total_lines_i)); // R4
  AST_IRQ2_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq2_o |-> $past({1'b0, tgt2_i} < total_lines_i)); // R4
  AST_IRQ1_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |=> !irq1_o); // R6
  AST_IRQ2_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq2_o |=> !irq2_o); // R6
  AST_FIRE_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq1_o || irq2_o) |-> ($past(line_i) != $past(line_i, 2))); // R5
  AST_IDLE_UNTIL_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_seen_i |-> (!irq1_o && !irq2_o)); // R8
endmodule

bind scan_irq_gen sirq_checker #(.LINE_W(LINE_W)) u_sirq_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_i        (line_i),
  .field_odd_i   (field_odd_i),
  .interlace_i   (interlace_i),
  .total_lines_i (total_lines_i),
  .tgt1_i        (tgt_q[0]),
  .tgt2_i        (tgt_q[1]),
  .cfg_seen_i    (cfg_seen),
  .irq1_o        (irq1_o),
  .irq2_o        (irq2_o)
);

// File: tb/scan_irq_gen_bench.sv
`timescale 1ns/1ps
module scan_irq_gen_bench;
  localparam int LINE_W = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [LINE_W-1:0] line_i = '0;
  logic              field_odd_i = 1'b0;
  logic              interlace_i = 1'b0;
  logic [LINE_W:0]   total_lines_i = 11'd20;
  logic              cfg_wr_i = 1'b0;
  logic [31:0]       cfg_data_i = '0;
  logic              geom_wr_i = 1'b0;
  logic              irq1_o, irq2_o;

  scan_irq_gen #(.LINE_W(LINE_W)) u_scan_irq_gen (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic  e1;
    logic  e2;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R8";

  // reference state, derived from the requirements
  int m_t1 = 0, m_t2 = 0, m_prev = 0;
  bit m_arm1 = 0, m_arm2 = 0, m_seen = 0;
  int line_r = 0, total_r = 20;
  bit field_r = 0, il_r = 0;

  function automatic int map_line(int t);
    return il_r ? (2 * t + int'(field_r)) : t;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  task automatic step(input bit wr, input logic [31:0] d, input bit geo);
    exp_t it;
    bit st;
    @(negedge clk_i);
    line_i        = line_r[LINE_W-1:0];
    field_odd_i   = field_r;
    interlace_i   = il_r;
    total_lines_i = total_r[LINE_W:0];
    cfg_wr_i      = wr;
    cfg_data_i    = d;
    geom_wr_i     = geo;
    st    = (line_r != m_prev);
    it.e1 = m_arm1 && st && (map_line(m_t1) == line_r) && (m_t1 < total_r);
    it.e2 = m_arm2 && st && (map_line(m_t2) == line_r) && (m_t2 < total_r);
    it.tag = tag;
    @(posedge clk_i);
    sb.push_back(it);
    m_prev = line_r;
    if (wr) begin
      m_t1 = int'(d[25:16]);
      m_t2 = int'(d[9:0]);
      m_seen = 1;
      m_arm1 = (m_t1 < total_r);
      m_arm2 = (m_t2 < total_r);
    end else if (geo && m_seen) begin
      m_arm1 = (m_t1 < total_r);
      m_arm2 = (m_t2 < total_r);
    end
  endtask

  task automatic run_lines(input int n);
    for (int i = 0; i < n; i++) begin
      line_r = (line_r + 1) % total_r;
      if (line_r == 0 && il_r) field_r = ~field_r;
      step(0, '0, 0);
    end
  endtask

  always @(negedge clk_i) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (irq1_o !== it.e1 || irq2_o !== it.e2) begin
        bad++;
        $display("FAIL %s line=%0d irq1/irq2 actual=%b%b expected=%b%b",
                 it.tag, line_i, irq1_o, irq2_o, it.e1, it.e2);
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    checks++;
    if (irq1_o !== 1'b0 || irq2_o !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset outputs actual=%b%b expected=00", irq1_o, irq2_o);
    end
    rst_ni = 1'b1;

    // R8: geometry strobe and full field before any configuration write
    tag = "R8";
    step(0, '0, 1);
    run_lines(20);

    // R1 R2 R7: junk in unused bits, targets 5 and 3, two fields
    tag = "R1";
    step(1, 32'hFC05_FC03, 0);
    run_lines(20);
    tag = "R7";
    run_lines(20);

    // R5: writes while raster sits on the target line
    tag = "R5";
    run_lines(3);
    step(1, 32'h0005_0003, 0);
    step(1, 32'h0003_0003, 0);
    run_lines(20);

    // R4: beyond total, exactly total, total-1
    tag = "R4";
    step(1, 32'h0019_0013, 0);
    run_lines(20);
    step(1, 32'h0014_0013, 0);
    run_lines(20);

    // R9: bigger total alone does not revive, geometry strobe does
    tag = "R9";
    total_r = 30;
    step(0, '0, 0);
    run_lines(30);
    step(0, '0, 1);
    run_lines(30);

    // R3: interlaced mapping, targets 4 and 7
    tag = "R3";
    total_r = 20;
    line_r = 0;
    il_r = 1;
    field_r = 0;
    step(0, '0, 0);
    step(1, 32'h0004_0007, 0);
    run_lines(40);

    // R10: equal targets, progressive
    tag = "R10";
    il_r = 0;
    field_r = 0;
    step(1, 32'h0006_0006, 0);
    run_lines(40);

    // R2: target zero fires on wrap
    tag = "R2";
    step(1, 32'h0000_000B, 0);
    run_lines(20);

    @(negedge clk_i);
    @(negedge clk_i);
    summary();
  end
endmodule